// File: doc/BRIEF.md
# Per-core coherence line state controller

This block tracks the four-state coherence condition (Modified, Exclusive, Shared, Invalid) of a small, directly indexed set of lines that belong to one core's private write-back cache. The line index is the address, and Modified doubles as the dirty mark. A single local request port carries loads, stores and locked read-modify-write stores. The block decides in the same cycle whether such a request may complete. When it may not, it sends the interconnect either a read request or a read-for-ownership (RFO) request, and holds the requester until the reply has filled the line.

On the other side, the block answers snoops from the interconnect. An invalidate snoop clears the line. A read snoop demotes an owned line to Shared. Both of them report a write-back when the line was dirty. A locked store takes the line and keeps it against every snoop until the core releases it. The interconnect may cancel a request instead of granting it, and the block then issues the request again.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and unlocked, no request goes to the interconnect, and a first load to any line needs an interconnect read.
- R2: A load to an Invalid line raises `bus_req_valid` with `bus_req_rfo`=0 for one cycle, starting the cycle after the load is presented. The line is filled when `rsp_valid` arrives with `rsp_ok`=1: Shared if `rsp_shared`=1, Exclusive if 0. The load completes in the next cycle. A load to a valid line completes in the cycle it is presented, with no interconnect traffic.
- R3: A store to an Exclusive or Modified line completes in the cycle it is presented and leaves the line Modified, with no interconnect request.
- R4: A store to a Shared or Invalid line is held (`req_ready`=0) and issues a request with `bus_req_rfo`=1. A granted reply makes the line Exclusive, and the store completes in the following cycle, making the line Modified.
- R5: A reply with `rsp_ok`=0 is a cancellation. It changes no line state, and the same request is issued again in the next cycle.
- R6: At most one interconnect request is outstanding. `bus_req_valid` is never high in two consecutive cycles, and no new request starts before the reply to the current one.
- R7: An invalidate snoop (`snp_inv`=1) is acknowledged in the same cycle and leaves the line Invalid. `snp_wb` is set with the acknowledge only when the line was Modified.
- R8: A read snoop (`snp_inv`=0) is acknowledged in the same cycle. It turns Exclusive or Modified into Shared, with `snp_wb`=1 only for Modified, and leaves Shared and Invalid lines as they are.
- R9: A store with `req_lock`=1 completes like any store and also locks the line. Snoops to a locked line get `snp_ack`=0 and leave it unchanged. Asserting `unlock_valid` releases the lock, and a snoop in that same cycle is served.
- R10: Within one cycle, a reply fill and a local store to the snooped line take effect before the snoop. The snoop answer and the resulting state follow from the updated line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present, held until req_ready |
| req_store | input | 1 | 1 = store, 0 = load |
| req_lock | input | 1 | Locked store (implies store) |
| req_line | input | IDX_W | Line index of the local request |
| req_ready | output | 1 | Local request completes this cycle |
| unlock_valid | input | 1 | Release the lock on unlock_line |
| unlock_line | input | IDX_W | Line to release |
| bus_req_valid | output | 1 | Interconnect request pulse |
| bus_req_rfo | output | 1 | 1 = read-for-ownership, 0 = read |
| bus_req_line | output | IDX_W | Line of the interconnect request |
| rsp_valid | input | 1 | Reply to the outstanding request |
| rsp_ok | input | 1 | 1 = granted, 0 = cancelled |
| rsp_shared | input | 1 | On a granted read: another cache holds the line |
| snp_valid | input | 1 | Incoming snoop, held until acknowledged |
| snp_inv | input | 1 | 1 = invalidate, 0 = read snoop |
| snp_line | input | IDX_W | Snooped line |
| snp_ack | output | 1 | Snoop served this cycle |
| snp_wb | output | 1 | Dirty data written back with the acknowledge |

## Verification
The case that needs care is a snoop landing on the same line, in the same cycle, as a local store completing or a reply filling the line. The bench produces the first by presenting a store to an Exclusive line together with an invalidate snoop on it, and expects a completed store, an acknowledge and a write-back. It produces the second by timing a read snoop to arrive with the granted read reply, and expects an acknowledge with no write-back, followed later by an RFO for a store, which shows the line ended Shared. A behavioural model applies the same ordering every cycle and compares all outputs.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2
    } miss_ph_e;

    typedef struct packed {
        mesi_e st;
        logic  lock;
    } slot_t;
endpackage

// File: rtl/coh_line_slot.sv
module coh_line_slot
    import mesi_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fill_en,
    input  mesi_e fill_st,
    input  logic  commit_en,
    input  logic  lock_en,
    input  logic  unlock_en,
    input  logic  snp_hit,
    input  logic  snp_inv,
    output mesi_e st_o,
    output logic  snp_ack_o,
    output logic  snp_wb_o
);
    slot_t slot_d, slot_q;

    // Order inside one cycle: fill, local commit, lock changes, then snoop.
    always_comb begin
        slot_d    = slot_q;
        snp_ack_o = 1'b0;
        snp_wb_o  = 1'b0;
        if (fill_en)   slot_d.st   = fill_st;
        if (commit_en) slot_d.st   = ST_M;
        if (lock_en)   slot_d.lock = 1'b1;
        if (unlock_en) slot_d.lock = 1'b0;
        if (snp_hit && !slot_d.lock) begin
            snp_ack_o = 1'b1;
            snp_wb_o  = (slot_d.st == ST_M);
            if (snp_inv)                slot_d.st = ST_I;
            else if (slot_d.st != ST_I) slot_d.st = ST_S;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '{st: ST_I, lock: 1'b0};
        else        slot_q <= slot_d;
    end

    assign st_o = slot_q.st;

    assert_lock_owns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q.lock |-> slot_q.st == ST_M);

    assert_locked_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q.lock && snp_hit && !unlock_en |=> slot_q.lock && $stable(slot_q.st));

    assert_inv_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hit && snp_inv && snp_ack_o |=> slot_q.st == ST_I);
endmodule

// File: rtl/coh_miss_seq.sv
module coh_miss_seq
    import mesi_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_rfo,
    input  logic [IDX_W-1:0] start_line,
    input  logic             rsp_valid,
    input  logic             rsp_ok,
    input  logic             rsp_shared,
    output logic             busy,
    output logic             bus_req_valid,
    output logic             bus_req_rfo,
    output logic [IDX_W-1:0] bus_req_line,
    output logic             fill_en,
    output logic [IDX_W-1:0] fill_line,
    output mesi_e            fill_st
);
    typedef struct packed {
        miss_ph_e         ph;
        logic             rfo;
        logic [IDX_W-1:0] line;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d   = seq_q;
        fill_en = 1'b0;
        case (seq_q.ph)
            PH_IDLE: if (start) begin
                seq_d.ph   = PH_ISSUE;
                seq_d.rfo  = start_rfo;
                seq_d.line = start_line;
            end
            PH_ISSUE: seq_d.ph = PH_WAIT;
            PH_WAIT: if (rsp_valid) begin
                if (rsp_ok) begin
                    fill_en  = 1'b1;
                    seq_d.ph = PH_IDLE;
                end else begin
                    seq_d.ph = PH_ISSUE;
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE, rfo: 1'b0, line: '0};
        else        seq_q <= seq_d;
    end

    assign busy          = (seq_q.ph != PH_IDLE);
    assign bus_req_valid = (seq_q.ph == PH_ISSUE);
    assign bus_req_rfo   = seq_q.rfo;
    assign bus_req_line  = seq_q.line;
    assign fill_line     = seq_q.line;
    assign fill_st       = seq_q.rfo ? ST_E : (rsp_shared ? ST_S : ST_E);

    assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |=> !bus_req_valid);

    assert_start_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    assert_cancel_retries_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.ph == PH_WAIT && rsp_valid && !rsp_ok
        |=> bus_req_valid && bus_req_line == $past(seq_q.line) && !fill_en);
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_store,
    input  logic             req_lock,
    input  logic [IDX_W-1:0] req_line,
    output logic             req_ready,
    input  logic             unlock_valid,
    input  logic [IDX_W-1:0] unlock_line,
    output logic             bus_req_valid,
    output logic             bus_req_rfo,
    output logic [IDX_W-1:0] bus_req_line,
    input  logic             rsp_valid,
    input  logic             rsp_ok,
    input  logic             rsp_shared,
    input  logic             snp_valid,
    input  logic             snp_inv,
    input  logic [IDX_W-1:0] snp_line,
    output logic             snp_ack,
    output logic             snp_wb
);
    mesi_e                st_arr [NUM_LINES];
    logic [NUM_LINES-1:0] commit_v, lock_v, unlock_v, snp_v, fill_v, ack_v, wb_v;
    logic                 need_own, hit, busy, miss_start, fill_en;
    logic [IDX_W-1:0]     fill_line;
    mesi_e                fill_st, cur_st;

    always_comb begin
        need_own   = req_store | req_lock;
        cur_st     = st_arr[req_line];
        hit        = need_own ? (cur_st == ST_E || cur_st == ST_M) : (cur_st != ST_I);
        req_ready  = req_valid && hit;
        miss_start = req_valid && !hit && !busy;
        for (int i = 0; i < NUM_LINES; i++) begin
            commit_v[i] = req_ready && need_own && (req_line == IDX_W'(i));
            lock_v[i]   = commit_v[i] && req_lock;
            unlock_v[i] = unlock_valid && (unlock_line == IDX_W'(i));
            snp_v[i]    = snp_valid && (snp_line == IDX_W'(i));
            fill_v[i]   = fill_en && (fill_line == IDX_W'(i));
        end
        snp_ack = |ack_v;
        snp_wb  = |wb_v;
    end

    coh_miss_seq #(.IDX_W(IDX_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (miss_start),
        .start_rfo    (need_own),
        .start_line   (req_line),
        .rsp_valid    (rsp_valid),
        .rsp_ok       (rsp_ok),
        .rsp_shared   (rsp_shared),
        .busy         (busy),
        .bus_req_valid(bus_req_valid),
        .bus_req_rfo  (bus_req_rfo),
        .bus_req_line (bus_req_line),
        .fill_en      (fill_en),
        .fill_line    (fill_line),
        .fill_st      (fill_st)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_slot
        coh_line_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .fill_en  (fill_v[g]),
            .fill_st  (fill_st),
            .commit_en(commit_v[g]),
            .lock_en  (lock_v[g]),
            .unlock_en(unlock_v[g]),
            .snp_hit  (snp_v[g]),
            .snp_inv  (snp_inv),
            .st_o     (st_arr[g]),
            .snp_ack_o(ack_v[g]),
            .snp_wb_o (wb_v[g])
        );
    end

    assert_store_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && need_own && !(snp_valid && snp_line == req_line)
        |=> st_arr[$past(req_line)] == ST_M);

    assert_stall_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req_valid && need_own && bus_req_line == req_line |-> !bus_req_valid || !req_ready);

    assert_single_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_v));
endmodule

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;
    localparam int N  = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_store = 0, req_lock = 0, unlock_valid = 0;
    logic [IW-1:0] req_line = '0, unlock_line = '0, snp_line = '0;
    logic rsp_valid = 0, rsp_ok = 0, rsp_shared = 0, snp_valid = 0, snp_inv = 0;
    logic req_ready, bus_req_valid, bus_req_rfo, snp_ack, snp_wb;
    logic [IW-1:0] bus_req_line;

    coh_line_ctrl #(.NUM_LINES(N)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_lock(req_lock), .req_line(req_line), .req_ready(req_ready),
        .unlock_valid(unlock_valid), .unlock_line(unlock_line),
        .bus_req_valid(bus_req_valid), .bus_req_rfo(bus_req_rfo),
        .bus_req_line(bus_req_line), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_shared(rsp_shared), .snp_valid(snp_valid), .snp_inv(snp_inv),
        .snp_line(snp_line), .snp_ack(snp_ack), .snp_wb(snp_wb)
    );

    always #4 clk = ~clk;

    int    tests = 0, fails = 0;
    string tag = "R1";
    int    m_st [N];
    bit    m_lk [N];
    int    ph = 0, p_line = 0;
    bit    p_rfo = 0;
    bit    o_ready, o_bus, o_ack, o_wb;

    task automatic chk(string t, int act, int exp, string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    function automatic bit m_hit(int l, bit own);
        return own ? (m_st[l] >= 2) : (m_st[l] != 0);
    endfunction

    // One clock: compare outputs against the model, then advance the model.
    task automatic cycle();
        bit own, e_ready, fill, miss, e_ack, e_wb;
        int st2;
        bit lk2;
        #2;
        own     = req_store | req_lock;
        e_ready = req_valid && m_hit(int'(req_line), own);
        miss    = req_valid && !e_ready && ph == 0;
        fill    = (ph == 2) && rsp_valid && rsp_ok;
        o_ready = req_ready; o_bus = bus_req_valid; o_ack = snp_ack; o_wb = snp_wb;
        chk(tag, int'(o_ready), int'(e_ready), "req_ready");
        chk(tag, int'(o_bus), int'(ph == 1), "bus_req_valid");
        if (ph == 1) begin
            chk(tag, int'(bus_req_rfo), int'(p_rfo), "bus_req_rfo");
            chk(tag, int'(bus_req_line), p_line, "bus_req_line");
        end
        e_ack = 0; e_wb = 0;
        for (int l = 0; l < N; l++) begin
            st2 = m_st[l]; lk2 = m_lk[l];
            if (fill && p_line == l) st2 = p_rfo ? 2 : (rsp_shared ? 1 : 2);
            if (e_ready && own && int'(req_line) == l) begin
                st2 = 3;
                if (req_lock) lk2 = 1;
            end
            if (unlock_valid && int'(unlock_line) == l) lk2 = 0;
            if (snp_valid && int'(snp_line) == l && !lk2) begin
                e_ack = 1;
                e_wb  = (st2 == 3);
                if (snp_inv) st2 = 0;
                else if (st2 != 0) st2 = 1;
            end
            m_st[l] = st2; m_lk[l] = lk2;
        end
        chk(tag, int'(o_ack), int'(e_ack), "snp_ack");
        chk(tag, int'(o_wb), int'(e_wb), "snp_wb");
        case (ph)
            0: if (miss) begin ph = 1; p_line = int'(req_line); p_rfo = own; end
            1: ph = 2;
            2: if (rsp_valid) ph = rsp_ok ? 0 : 1;
            default: ph = 0;
        endcase
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_req(int line, bit st, bit lk, bit shr, int ncancel,
                          output int nbus, output int ncyc);
        req_valid = 1; req_store = st; req_lock = lk; req_line = IW'(line);
        nbus = 0; ncyc = 0;
        for (int k = 0; k < 40; k++) begin
            cycle();
            ncyc++;
            rsp_valid = 0;
            if (o_ready) break;
            if (o_bus) begin
                nbus++;
                rsp_valid = 1; rsp_shared = shr; rsp_ok = (ncancel == 0);
                if (ncancel > 0) ncancel--;
            end
        end
        req_valid = 0; req_store = 0; req_lock = 0; rsp_valid = 0;
    endtask

    task automatic snoop(int line, bit inv, bit unl, output bit ack, output bit wb);
        snp_valid = 1; snp_inv = inv; snp_line = IW'(line);
        unlock_valid = unl; unlock_line = IW'(line);
        cycle();
        ack = o_ack; wb = o_wb;
        snp_valid = 0; unlock_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R6 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int nb, nc;
        bit a, w;
        for (int l = 0; l < N; l++) begin m_st[l] = 0; m_lk[l] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        tag = "R1";
        cycle();
        chk("R1", int'(o_bus), 0, "idle bus after reset");
        chk("R1", int'(o_ready), 0, "idle ready after reset");

        tag = "R2";
        do_req(0, 0, 0, 0, 0, nb, nc);
        chk("R1", nb, 1, "first load bus requests");
        chk("R2", nc, 4, "read miss latency");
        do_req(0, 0, 0, 0, 0, nb, nc);
        chk("R2", nb, 0, "load hit bus requests");
        chk("R2", nc, 1, "load hit latency");

        tag = "R3";
        do_req(0, 1, 0, 0, 0, nb, nc);
        chk("R3", nb, 0, "store to Exclusive bus requests");
        chk("R3", nc, 1, "store to Exclusive latency");

        tag = "R8";
        snoop(0, 0, 0, a, w);
        chk("R8", int'(w), 1, "read snoop on Modified write-back");
        snoop(0, 0, 0, a, w);
        chk("R8", int'(a), 1, "read snoop on Shared ack");
        chk("R8", int'(w), 0, "read snoop on Shared write-back");

        tag = "R4";
        do_req(0, 1, 0, 0, 0, nb, nc);
        chk("R4", nb, 1, "store to Shared RFO count");
        chk("R4", nc, 4, "store to Shared latency");

        tag = "R7";
        snoop(0, 1, 0, a, w);
        chk("R7", int'(w), 1, "invalidate Modified write-back");

        tag = "R5";
        do_req(1, 0, 0, 1, 0, nb, nc);
        do_req(1, 1, 0, 0, 1, nb, nc);
        chk("R5", nb, 2, "cancelled RFO reissued");
        chk("R5", nc, 6, "cancelled RFO latency");
        chk("R6", nb, 2, "requests per store, one outstanding");

        tag = "R7";
        snoop(1, 1, 0, a, w);
        chk("R7", int'(w), 1, "invalidate after RFO store write-back");
        do_req(1, 0, 0, 1, 0, nb, nc);
        snoop(1, 1, 0, a, w);
        chk("R7", int'(a), 1, "invalidate Shared ack");
        chk("R7", int'(w), 0, "invalidate Shared write-back");
        do_req(1, 0, 0, 1, 0, nb, nc);
        chk("R7", nb, 1, "line Invalid after invalidate");
        snoop(2, 1, 0, a, w);
        chk("R7", int'(a), 1, "invalidate on Invalid ack");

        tag = "R9";
        do_req(2, 0, 0, 0, 0, nb, nc);
        do_req(2, 1, 1, 0, 0, nb, nc);
        chk("R9", nc, 1, "locked store latency");
        for (int k = 0; k < 3; k++) begin
            snoop(2, 1, 0, a, w);
            chk("R9", int'(a), 0, "snoop to locked line ack");
        end
        snoop(2, 1, 1, a, w);
        chk("R9", int'(a), 1, "snoop with unlock ack");
        chk("R9", int'(w), 1, "snoop with unlock write-back");
        do_req(2, 0, 0, 0, 0, nb, nc);
        chk("R9", nb, 1, "line Invalid after released snoop");

        tag = "R10";
        do_req(3, 0, 0, 0, 0, nb, nc);
        req_valid = 1; req_store = 1; req_line = 2'd3;
        snp_valid = 1; snp_inv = 1; snp_line = 2'd3;
        cycle();
        chk("R10", int'(o_ready), 1, "store beside snoop ready");
        chk("R10", int'(o_ack), 1, "snoop beside store ack");
        chk("R10", int'(o_wb), 1, "snoop beside store write-back");
        req_valid = 0; req_store = 0; snp_valid = 0;

        req_valid = 1; req_line = 2'd0;
        cycle();
        cycle();
        chk("R10", int'(o_bus), 1, "read request before fill");
        rsp_valid = 1; rsp_ok = 1; rsp_shared = 0;
        snp_valid = 1; snp_inv = 0; snp_line = 2'd0;
        cycle();
        chk("R10", int'(o_ack), 1, "snoop beside fill ack");
        chk("R10", int'(o_wb), 0, "snoop beside fill write-back");
        rsp_valid = 0; snp_valid = 0;
        cycle();
        chk("R10", int'(o_ready), 1, "load after fill ready");
        req_valid = 0;
        do_req(0, 1, 0, 0, 0, nb, nc);
        chk("R10", nb, 1, "line Shared after fill and snoop");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule